// File: doc/BRIEF.md
# Phase-Frequency Detector with Pump Control

This block compares two divided clocks, a reference and a feedback, and produces the up and down commands for a charge pump. Each of the two inputs has a rising-edge flag of its own. The leading edge raises its command, and that command stays high until the lagging edge arrives. Once both flags are set, they stay set together for a programmable number of cycles and then clear together. This short forced overlap gives a pump pulse even at zero phase error, so the loop has no dead zone.

A polarity input swaps up and down to suit a VCO with either tuning slope. A gain-select input chooses a pump current code, either low or ten times higher. A low enable clears the detector and the lock filter, and forces the pump to high impedance.

A lock flag rises after a programmable number of consecutive comparisons in which the single-command interval stayed shorter than a threshold. Any interval that reaches the threshold drops the flag at once. The ports are plain control and status pins, sampled on the block clock. There is no data stream, so there is no back-pressure.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: With polarity 0, a reference edge that leads the feedback edge by d cycles gives exactly d cycles with pump_up high and pump_dn low. The first of these cycles follows the clock edge that samples the reference high.
- R2: With polarity 0, a feedback edge that leads by d cycles gives exactly d cycles with pump_dn high and pump_up low.
- R3: Once both flags are set, pump_up and pump_dn are both high for exactly max(ovl_cycles,1) cycles and then both clear. This also holds for coincident edges, where the overlap is the whole pulse.
- R4: With polarity 1, the roles of pump_up and pump_dn in R1 and R2 are swapped.
- R5: While enable is low, pump_up and pump_dn are low and pump_hiz is high. From the next cycle locked is low. Edges seen while disabled produce no pulse.
- R6: pump_hiz is high exactly when neither pump_up nor pump_dn is high.
- R7: gain_code is 160 when gain_hi is 0 and 1600 when gain_hi is 1.
- R8: locked rises one cycle after the clearing of the lock_need-th consecutive comparison in which the single-command interval stayed shorter than lock_thresh cycles.
- R9: In the cycle in which a single-command interval reaches lock_thresh cycles, the design clears the good-comparison streak, and locked is low from the next cycle.
- R10: After reset, pump_up, pump_dn and locked are low and pump_hiz is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_div | input | 1 | Divided reference clock |
| fb_div | input | 1 | Divided feedback clock |
| enable | input | 1 | Low clears the detector and tristates the pump |
| polarity | input | 1 | 1 swaps up and down |
| gain_hi | input | 1 | Selects the high pump current |
| ovl_cycles | input | OVL_W | Forced overlap length (0 acts as 1) |
| lock_thresh | input | WID_W | Single-command width that counts as too wide |
| lock_need | input | LCNT_W | Good comparisons needed for lock |
| pump_up | output | 1 | Pump-up command |
| pump_dn | output | 1 | Pump-down command |
| pump_hiz | output | 1 | Pump output is high impedance |
| gain_code | output | GAIN_W | Selected pump current code |
| locked | output | 1 | Lock flag |

## Verification
The properties assume that ovl_cycles and lock_thresh hold steady while a comparison is in progress. They also assume that the divided inputs are synchronous to the block clock and that each input stays high for longer than one cycle. The stimulus changes the settings only between comparison periods, when both commands are idle. It drives each divided clock as a 20-cycle-high pulse in a 48-cycle period, with phase offsets kept well inside that period, so every edge falls outside the overlap window.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_pair_t;

  function automatic int pump_current(input logic hi, input int lo, input int ratio);
    return hi ? lo * ratio : lo;
  endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] sig,
  output logic [LANES-1:0] rise
);
  logic [LANES-1:0] prev;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[i] <= 1'b0;
      else        prev[i] <= sig[i];
    end
    assign rise[i] = sig[i] & ~prev[i];
  end
endmodule

// File: rtl/pfd_flags.sv
module pfd_flags
  import pfd_pkg::*;
#(
  parameter int OVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             rise_ref,
  input  logic             rise_fb,
  input  logic [OVL_W-1:0] ovl_cycles,
  output pump_pair_t       flags,
  output logic             cmp_done
);
  logic [OVL_W-1:0] cnt;
  logic [OVL_W-1:0] ovl_eff;
  logic [OVL_W:0]   cnt_next;
  logic             both;

  assign ovl_eff  = (ovl_cycles == '0) ? OVL_W'(1) : ovl_cycles;
  assign cnt_next = {1'b0, cnt} + (OVL_W+1)'(1);
  assign both     = flags.up & flags.dn;
  assign cmp_done = enable & both & (cnt_next >= {1'b0, ovl_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      cnt   <= '0;
    end else if (!enable) begin
      flags <= '0;
      cnt   <= '0;
    end else if (both) begin
      if (cmp_done) begin
        flags <= '0;
        cnt   <= '0;
      end else begin
        cnt <= cnt_next[OVL_W-1:0];
      end
    end else begin
      if (rise_ref) flags.up <= 1'b1;
      if (rise_fb)  flags.dn <= 1'b1;
    end
  end
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter
  import pfd_pkg::*;
#(
  parameter int WID_W  = 6,
  parameter int LCNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  pump_pair_t        flags,
  input  logic              cmp_done,
  input  logic [WID_W-1:0]  lock_thresh,
  input  logic [LCNT_W-1:0] lock_need,
  output logic              locked
);
  logic [WID_W-1:0]  wcnt;
  logic [LCNT_W-1:0] good;
  logic              wide;
  logic              single;
  logic              hit;
  logic [WID_W:0]    w_next;
  logic [LCNT_W:0]   g_next;

  assign single = flags.up ^ flags.dn;
  assign w_next = {1'b0, wcnt} + (WID_W+1)'(1);
  assign g_next = {1'b0, good} + (LCNT_W+1)'(1);
  assign hit    = single & (w_next >= {1'b0, lock_thresh});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0; good <= '0; wide <= 1'b0; locked <= 1'b0;
    end else if (!enable) begin
      wcnt <= '0; good <= '0; wide <= 1'b0; locked <= 1'b0;
    end else begin
      if (single && !w_next[WID_W]) wcnt <= w_next[WID_W-1:0];
      if (hit) begin
        wide   <= 1'b1;
        good   <= '0;
        locked <= 1'b0;
      end
      if (cmp_done) begin
        wcnt <= '0;
        wide <= 1'b0;
        if (!wide) begin
          if (!g_next[LCNT_W]) good <= g_next[LCNT_W-1:0];
          if (g_next >= {1'b0, lock_need}) locked <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pfd_pump_out.sv
module pfd_pump_out
  import pfd_pkg::*;
#(
  parameter int CUR_LO    = 160,
  parameter int CUR_RATIO = 10,
  parameter int GAIN_W    = 11
) (
  input  logic              enable,
  input  logic              polarity,
  input  logic              gain_hi,
  input  pump_pair_t        flags,
  output logic              pump_up,
  output logic              pump_dn,
  output logic              pump_hiz,
  output logic [GAIN_W-1:0] gain_code
);
  assign pump_up   = enable & (polarity ? flags.dn : flags.up);
  assign pump_dn   = enable & (polarity ? flags.up : flags.dn);
  assign pump_hiz  = ~(pump_up | pump_dn);
  assign gain_code = GAIN_W'(pump_current(gain_hi, CUR_LO, CUR_RATIO));
endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl
  import pfd_pkg::*;
#(
  parameter int OVL_W     = 4,
  parameter int WID_W     = 6,
  parameter int LCNT_W    = 6,
  parameter int CUR_LO    = 160,
  parameter int CUR_RATIO = 10,
  parameter int GAIN_W    = $clog2(CUR_LO * CUR_RATIO + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_div,
  input  logic              fb_div,
  input  logic              enable,
  input  logic              polarity,
  input  logic              gain_hi,
  input  logic [OVL_W-1:0]  ovl_cycles,
  input  logic [WID_W-1:0]  lock_thresh,
  input  logic [LCNT_W-1:0] lock_need,
  output logic              pump_up,
  output logic              pump_dn,
  output logic              pump_hiz,
  output logic [GAIN_W-1:0] gain_code,
  output logic              locked
);
  logic [1:0] rise;
  pump_pair_t flags;
  logic       cmp_done;

  pfd_edge_det #(.LANES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig({fb_div, ref_div}), .rise(rise)
  );

  pfd_flags #(.OVL_W(OVL_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .rise_ref(rise[0]), .rise_fb(rise[1]),
    .ovl_cycles(ovl_cycles), .flags(flags), .cmp_done(cmp_done)
  );

  pfd_lock_filter #(.WID_W(WID_W), .LCNT_W(LCNT_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flags(flags),
    .cmp_done(cmp_done), .lock_thresh(lock_thresh),
    .lock_need(lock_need), .locked(locked)
  );

  pfd_pump_out #(.CUR_LO(CUR_LO), .CUR_RATIO(CUR_RATIO), .GAIN_W(GAIN_W)) u_out (
    .enable(enable), .polarity(polarity), .gain_hi(gain_hi), .flags(flags),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
    .gain_code(gain_code)
  );
endmodule

// File: rtl/pfd_pump_chk.sv
module pfd_pump_chk #(
  parameter int OVL_W = 4,
  parameter int WID_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [OVL_W-1:0] ovl_cycles,
  input logic [WID_W-1:0] lock_thresh,
  input logic             pump_up,
  input logic             pump_dn,
  input logic             pump_hiz,
  input logic             locked
);
  int ov_q;
  int run_q;
  int ovl_eff;

  assign ovl_eff = (ovl_cycles == '0) ? 1 : int'(ovl_cycles);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q  <= 0;
      run_q <= 0;
    end else begin
      ov_q  <= (pump_up && pump_dn) ? ov_q + 1 : 0;
      run_q <= (pump_up ^ pump_dn) ? ((run_q < 1000000) ? run_q + 1 : run_q) : 0;
    end
  end

  assert_overlap_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && pump_dn) |-> (ov_q < ovl_eff));

  assert_disable_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (pump_hiz && !pump_up && !pump_dn));

  assert_disable_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !locked);

  assert_wide_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pump_up ^ pump_dn) && (run_q + 1 >= int'(lock_thresh))) |=> !locked);

  assert_hiz_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pump_hiz |-> !(pump_up || pump_dn));
endmodule

bind pfd_pump_ctrl pfd_pump_chk #(.OVL_W(OVL_W), .WID_W(WID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .ovl_cycles(ovl_cycles),
  .lock_thresh(lock_thresh), .pump_up(pump_up), .pump_dn(pump_dn),
  .pump_hiz(pump_hiz), .locked(locked)
);

// File: tb/sim_pfd_pump_ctrl.sv
module sim_pfd_pump_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_div = 1'b0, fb_div = 1'b0;
  logic        enable = 1'b0, polarity = 1'b0, gain_hi = 1'b0;
  logic [3:0]  ovl_cycles = 4'd1;
  logic [5:0]  lock_thresh = 6'd3;
  logic [5:0]  lock_need = 6'd4;
  logic        pump_up, pump_dn, pump_hiz, locked;
  logic [10:0] gain_code;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct { int up; int dn; int ov; } ev_t;
  ev_t expq[$];

  always #10 clk = ~clk;

  pfd_pump_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_div(fb_div),
    .enable(enable), .polarity(polarity), .gain_hi(gain_hi),
    .ovl_cycles(ovl_cycles), .lock_thresh(lock_thresh), .lock_need(lock_need),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
    .gain_code(gain_code), .locked(locked)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one comparison period, reference rises at cycle 10, feedback at 10+d
  task automatic run_period(input int d, input bit push);
    ev_t e;
    int lead_up, lead_dn;
    lead_up = (d > 0) ? d : 0;
    lead_dn = (d < 0) ? -d : 0;
    e.up = polarity ? lead_dn : lead_up;
    e.dn = polarity ? lead_up : lead_dn;
    e.ov = (ovl_cycles == 0) ? 1 : int'(ovl_cycles);
    if (push) expq.push_back(e);
    for (int c = 0; c < 48; c++) begin
      @(negedge clk);
      ref_div = (c >= 10 && c < 30);
      fb_div  = (c >= 10 + d && c < 30 + d);
    end
  endtask

  // monitor: measures each pump pulse and compares with the queued item
  int cu = 0, cd = 0, co = 0;
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      check("R6", int'(pump_hiz), int'(!(pump_up || pump_dn)));
      if (pump_up || pump_dn) begin
        if (pump_up && pump_dn) co++;
        else if (pump_up) cu++;
        else cd++;
      end else if (cu + cd + co > 0) begin
        if (expq.size() == 0) begin
          check("R5 unexpected pulse", cu + cd + co, 0);
        end else begin
          ev_t e;
          e = expq.pop_front();
          check("R1/R4 up-only cycles", cu, e.up);
          check("R2/R4 dn-only cycles", cd, e.dn);
          check("R3 overlap cycles", co, e.ov);
        end
        cu = 0; cd = 0; co = 0;
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 up", int'(pump_up), 0);
    check("R10 dn", int'(pump_dn), 0);
    check("R10 hiz", int'(pump_hiz), 1);
    check("R10 locked", int'(locked), 0);
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check("R7 low gain", int'(gain_code), 160);
    gain_hi = 1'b1;
    @(negedge clk);
    check("R7 high gain", int'(gain_code), 1600);

    run_period(3, 1);    // R1 reference leads
    run_period(-4, 1);   // R2 feedback leads
    run_period(0, 1);    // R3 coincident edges
    ovl_cycles = 4'd3;
    run_period(2, 1);    // R3 longer overlap
    ovl_cycles = 4'd0;
    run_period(-1, 1);   // R3 zero acts as one
    ovl_cycles = 4'd1;
    polarity = 1'b1;
    run_period(3, 1);    // R4 swap
    run_period(-2, 1);   // R4 swap
    polarity = 1'b0;

    // R8 and R9 lock filter
    run_period(5, 1);
    run_period(2, 1);
    run_period(2, 1);
    run_period(2, 1);
    check("R8 not yet locked", int'(locked), 0);
    run_period(1, 1);
    check("R8 locked", int'(locked), 1);
    run_period(4, 1);
    check("R9 wide pulse unlocks", int'(locked), 0);
    run_period(-2, 1);
    run_period(-1, 1);
    run_period(0, 1);
    check("R9 streak restarted", int'(locked), 0);
    run_period(2, 1);
    check("R8 relock", int'(locked), 1);

    // R5 disable
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R5 locked cleared", int'(locked), 0);
    check("R5 hiz", int'(pump_hiz), 1);
    run_period(2, 0);
    run_period(-3, 0);
    check("R5 no pulses while disabled", expq.size(), 0);
    check("R5 hiz held", int'(pump_hiz), 1);
    enable = 1'b1;
    run_period(1, 1);
    repeat (4) @(negedge clk);
    check("R1 queue drained", expq.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule